// File: doc/BRIEF.md
# Three-Channel Interval Timer with Dual Compare

This block holds three independent 32-bit counters behind a small word-addressed register bus. Each channel has a live count, a reload value and two compare values. A channel counts up or down. It steps on every bus-clock cycle, or once for each rising edge of a shared external tick that is synchronised inside the block. When the count runs past its end (all-ones going up, zero going down), the channel reloads from its reload value.

A single control word packs the per-channel settings. Three event sources per channel feed a sticky status word: compare A hit, compare B hit and wrap. Software clears a status bit by writing 1 to it. A mask word of the same layout gates the status bits into one level interrupt output.

The bus is a plain one-cycle register port with no handshake. A write takes effect at the clock edge on which `reg_wen` is high, and reads are combinational from the current register state. Only word-aligned addresses (`reg_addr[1:0] == 0`) decode; anything else is ignored and reads as zero.

Top module: `trio_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: Channel n (1..3) has four read/write words at byte offset (n-1)*0x10: count +0x0, reload +0x4, compare A +0x8, compare B +0xC. The control word at 0x30 keeps bits 11:0, and its bits 31:12 read 0. The status word at 0x34 and the mask word at 0x38 keep bits 8:0.
- R3: With control bit 3(n-1) (run) set, bit 3(n-1)+1 (tick select) clear and bit 9+(n-1) (direction) set to 1, the count rises by one on every clock edge.
- R4: With direction 0, the count falls by one on every step.
- R5: A step from all-ones (counting up) or from zero (counting down) loads the reload value instead.
- R6: Status bit 3(n-1)+2 is set on a wrap only when control bit 3(n-1)+2 (wrap event enable) is set.
- R7: While the channel runs, status bit 3(n-1) is set when the count equals compare A, and status bit 3(n-1)+1 is set when the count equals compare B.
- R8: Status bits stay set until a 1 is written to them. When a new event and a clear hit the same bit in the same cycle, the event wins and the bit stays 1.
- R9: `irq` is 1 exactly when some status bit is 1 and its mask bit at the same position is 0.
- R10: With tick select set, a running channel advances once per rising edge of `ext_tick`, after a two-stage synchroniser. It does not advance while the tick is held high or low.
- R11: A channel whose run bit is clear keeps its count and raises no compare event.
- R12: A bus write to the count word takes precedence over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Write strobe, one word per cycle |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ext_tick | input | 1 | Asynchronous external step source |
| irq | output | 1 | OR of unmasked status bits |

## Verification
Two pairs of actions can fall on the same edge. The first pair is a compare hit and a software clear of the same status bit. The bench holds a channel in tick mode with no tick, so its count sits on compare A and the hit repeats every cycle. It then writes 1 to that status bit and expects to read it back as still set. Once the channel is stopped, the same write must clear the bit. The second pair is a step and a software write to the count. The bench writes the count while the channel runs, then stops the channel one cycle later. It judges the final count as the written value plus exactly one step.

// File: rtl/trio_timer_pkg.sv
package trio_timer_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned SLOT_BYTES = 16;
  localparam int unsigned EVT_PER_CH = 3;

  typedef enum logic [1:0] {
    SL_COUNT  = 2'd0,
    SL_RELOAD = 2'd1,
    SL_CMP_A  = 2'd2,
    SL_CMP_B  = 2'd3
  } slot_e;
endpackage

// File: rtl/trio_tick_sync.sv
module trio_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tick_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign tick_pulse = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/trio_timer_lane.sv
module trio_timer_lane
  import trio_timer_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         count_up,
  input  logic         use_tick,
  input  logic         tick,
  input  logic         wr_en,
  input  slot_e        wr_slot,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_o,
  output logic [W-1:0] reload_o,
  output logic [W-1:0] cmp_a_o,
  output logic [W-1:0] cmp_b_o,
  output logic         hit_a,
  output logic         hit_b,
  output logic         wrap
);
  logic [W-1:0] count_q, reload_q, cmp_a_q, cmp_b_q;
  logic         advance, at_end, count_wr;

  assign advance  = run & (use_tick ? tick : 1'b1);
  assign at_end   = count_up ? (count_q == {W{1'b1}}) : (count_q == '0);
  assign count_wr = wr_en && (wr_slot == SL_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      cmp_a_q  <= '0;
      cmp_b_q  <= '0;
    end else begin
      if (count_wr)            count_q <= wr_data;
      else if (advance) begin
        if (at_end)            count_q <= reload_q;
        else if (count_up)     count_q <= count_q + 1'b1;
        else                   count_q <= count_q - 1'b1;
      end
      if (wr_en && wr_slot == SL_RELOAD) reload_q <= wr_data;
      if (wr_en && wr_slot == SL_CMP_A)  cmp_a_q  <= wr_data;
      if (wr_en && wr_slot == SL_CMP_B)  cmp_b_q  <= wr_data;
    end
  end

  assign hit_a    = run && (count_q == cmp_a_q);
  assign hit_b    = run && (count_q == cmp_b_q);
  assign wrap     = advance && at_end && !count_wr;
  assign count_o  = count_q;
  assign reload_o = reload_q;
  assign cmp_a_o  = cmp_a_q;
  assign cmp_b_o  = cmp_b_q;
endmodule

// File: rtl/trio_timer.sv
module trio_timer
  import trio_timer_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 3,
  parameter int unsigned CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ext_tick,
  output logic              irq
);
  localparam int unsigned CTRL_BITS = 4 * NUM_TIMERS;
  localparam int unsigned EVT_BITS  = EVT_PER_CH * NUM_TIMERS;
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(SLOT_BYTES * NUM_TIMERS);
  localparam logic [ADDR_W-1:0] STAT_OFS = CTRL_OFS + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] MASK_OFS = CTRL_OFS + ADDR_W'(8);

  logic [CTRL_BITS-1:0]              ctrl_q;
  logic [EVT_BITS-1:0]               stat_q, mask_q, stat_set, stat_clr;
  logic [NUM_TIMERS-1:0]             lane_we, cnt_wr;
  logic [NUM_TIMERS-1:0][CNT_W-1:0]  cnt_v, rld_v, cma_v, cmb_v;
  logic                              aligned, in_lanes, stat_wr, tick_pulse;
  slot_e                             slot;

  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign in_lanes = aligned && (reg_addr < CTRL_OFS);
  assign slot     = slot_e'(reg_addr[3:2]);
  assign stat_wr  = reg_wen && aligned && (reg_addr == STAT_OFS);

  trio_tick_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick_in(ext_tick), .tick_pulse(tick_pulse)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_lane
    logic hit_a, hit_b, wrap;
    assign lane_we[i] = reg_wen && in_lanes && (reg_addr[7:4] == 4'(i));
    assign cnt_wr[i]  = lane_we[i] && (slot == SL_COUNT);

    trio_timer_lane #(.W(CNT_W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .run(ctrl_q[3*i]), .use_tick(ctrl_q[3*i+1]),
      .count_up(ctrl_q[3*NUM_TIMERS+i]), .tick(tick_pulse),
      .wr_en(lane_we[i]), .wr_slot(slot), .wr_data(reg_wdata[CNT_W-1:0]),
      .count_o(cnt_v[i]), .reload_o(rld_v[i]), .cmp_a_o(cma_v[i]), .cmp_b_o(cmb_v[i]),
      .hit_a(hit_a), .hit_b(hit_b), .wrap(wrap)
    );

    assign stat_set[3*i]   = hit_a;
    assign stat_set[3*i+1] = hit_b;
    assign stat_set[3*i+2] = wrap && ctrl_q[3*i+2];
  end

  assign stat_clr = stat_wr ? reg_wdata[EVT_BITS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      if (reg_wen && aligned && reg_addr == CTRL_OFS) ctrl_q <= reg_wdata[CTRL_BITS-1:0];
      if (reg_wen && aligned && reg_addr == MASK_OFS) mask_q <= reg_wdata[EVT_BITS-1:0];
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_lanes) begin
      for (int i = 0; i < NUM_TIMERS; i++) begin
        if (reg_addr[7:4] == 4'(i)) begin
          case (slot)
            SL_COUNT:  reg_rdata = REG_W'(cnt_v[i]);
            SL_RELOAD: reg_rdata = REG_W'(rld_v[i]);
            SL_CMP_A:  reg_rdata = REG_W'(cma_v[i]);
            default:   reg_rdata = REG_W'(cmb_v[i]);
          endcase
        end
      end
    end else if (aligned && reg_addr == CTRL_OFS) reg_rdata = REG_W'(ctrl_q);
    else if (aligned && reg_addr == STAT_OFS)     reg_rdata = REG_W'(stat_q);
    else if (aligned && reg_addr == MASK_OFS)     reg_rdata = REG_W'(mask_q);
  end

  assign irq = |(stat_q & ~mask_q);
endmodule

// File: rtl/trio_timer_chk.sv
module trio_timer_chk #(
  parameter int unsigned NUM = 3,
  parameter int unsigned W   = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [4*NUM-1:0]       ctrl,
  input logic [3*NUM-1:0]       stat,
  input logic                   tick,
  input logic [NUM-1:0][W-1:0]  cnt_v,
  input logic [NUM-1:0]         cnt_wr,
  input logic                   stat_wr
);
  // R8: without a status write no set bit drops
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((stat & $past(stat)) == $past(stat)));

  for (genvar i = 0; i < NUM; i++) begin : g_ch
    // R6: wrap event bit only rises with its enable set
    a_r6_wrap_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[3*i+2]) |-> $past(ctrl[3*i+2]));
    // R11: stopped channel holds its count
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[3*i] && !cnt_wr[i]) |=> $stable(cnt_v[i]));
    // R10: tick mode without a pulse holds the count
    a_r10_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[3*i] && ctrl[3*i+1] && !tick && !cnt_wr[i]) |=> $stable(cnt_v[i]));
    // R3: free-running up count steps by one
    a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[3*i] && !ctrl[3*i+1] && ctrl[3*NUM+i] && !cnt_wr[i] && cnt_v[i] != {W{1'b1}})
      |=> cnt_v[i] == $past(cnt_v[i]) + {{(W-1){1'b0}}, 1'b1});
  end
endmodule

bind trio_timer trio_timer_chk #(.NUM(NUM_TIMERS), .W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .stat(stat_q), .tick(tick_pulse),
  .cnt_v(cnt_v), .cnt_wr(cnt_wr), .stat_wr(stat_wr)
);

// File: tb/trio_timer_test.sv
module trio_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ext_tick = 1'b0;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  localparam logic [7:0] CTRL = 8'h30, STAT = 8'h34, MASK = 8'h38;

  always #2.5 clk = ~clk;

  trio_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_tick(ext_tick), .irq(irq)
  );

  function automatic logic [7:0] tw(int n, int slot);
    return 8'((n - 1) * 16 + slot * 4);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a <= 8'h38; a += 4) begin
      rd(8'(a), d); check("R1 reset value", d, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(tw(2, 1), 32'hDEADBEEF); rd(tw(2, 1), d); check("R2 reload rw", d, 32'hDEADBEEF);
    wr(tw(3, 3), 32'hA5A50001); rd(tw(3, 3), d); check("R2 compare B rw", d, 32'hA5A50001);
    wr(CTRL, 32'hFFFFFE00); rd(CTRL, d); check("R2 ctrl reserved", d, 32'h00000E00);
    wr(CTRL, 0);
    wr(MASK, 32'hFFFFFFFF); rd(MASK, d); check("R2 mask width", d, 32'h1FF);
    wr(MASK, 0);
  endtask

  task automatic t_up_match;
    logic [31:0] d;
    wr(STAT, 32'h1FF);
    wr(tw(1, 0), 10); wr(tw(1, 2), 12); wr(tw(1, 3), 100);
    wr(CTRL, 32'h201); idle(3); wr(CTRL, 0);   // 4 steps
    rd(tw(1, 0), d); check("R3 up count", d, 14);
    rd(STAT, d); check("R7 compare A hit only", d, 32'h1);
    wr(STAT, 32'h1); rd(STAT, d); check("R8 write one clears", d, 0);
  endtask

  task automatic t_down_wrap;
    logic [31:0] d;
    wr(tw(2, 1), 50); wr(tw(2, 0), 2); wr(tw(2, 2), 32'h1000); wr(tw(2, 3), 32'h2000);
    wr(CTRL, 32'h28); idle(4); wr(CTRL, 0);    // 5 steps: 2,1,0,50,49,48
    rd(tw(2, 0), d); check("R4 R5 down count and reload", d, 48);
    rd(STAT, d); check("R6 wrap event enabled", d, 32'h20);
    check("R9 irq unmasked", {31'b0, irq}, 1);
    wr(MASK, 32'h20); #1; check("R9 irq masked", {31'b0, irq}, 0);
    wr(MASK, 32'h1DF); #1; check("R9 other mask bits", {31'b0, irq}, 1);
    wr(MASK, 0); wr(STAT, 32'h20); #1;
    check("R9 irq after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_up_wrap_gated;
    logic [31:0] d;
    wr(tw(3, 1), 7); wr(tw(3, 0), 32'hFFFFFFFE); wr(tw(3, 2), 32'h100); wr(tw(3, 3), 32'h200);
    wr(CTRL, 32'h840); idle(2); wr(CTRL, 0);   // 3 steps: FE,FF,7,8
    rd(tw(3, 0), d); check("R5 up wrap reload", d, 8);
    rd(STAT, d); check("R6 wrap event disabled", d, 0);
  endtask

  task automatic t_ext_tick;
    logic [31:0] d;
    wr(tw(1, 0), 0); wr(tw(1, 2), 32'h100); wr(tw(1, 3), 32'h200);
    wr(CTRL, 32'h203); idle(5);
    rd(tw(1, 0), d); check("R10 no tick no step", d, 0);
    ext_tick = 1'b1; idle(8);
    rd(tw(1, 0), d); check("R10 one step while held high", d, 1);
    ext_tick = 1'b0; idle(4); ext_tick = 1'b1; idle(8); ext_tick = 1'b0;
    wr(CTRL, 0);
    rd(tw(1, 0), d); check("R10 second edge", d, 2);
    wr(STAT, 32'h1FF);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    wr(tw(3, 0), 32'h55); wr(tw(3, 2), 32'h55); wr(CTRL, 0); idle(5);
    rd(tw(3, 0), d); check("R11 count held", d, 32'h55);
    rd(STAT, d); check("R11 no compare event", d, 0);
  endtask

  task automatic t_write_wins;
    logic [31:0] d;
    wr(tw(1, 0), 5); wr(CTRL, 32'h201); wr(tw(1, 0), 1000); wr(CTRL, 0);
    rd(tw(1, 0), d); check("R12 write beats step", d, 1001);
    wr(STAT, 32'h1FF);
  endtask

  task automatic t_set_beats_clear;
    logic [31:0] d;
    wr(tw(1, 0), 32'h300); wr(tw(1, 2), 32'h300);
    wr(CTRL, 32'h203); idle(2);
    wr(STAT, 32'h1); rd(STAT, d); check("R8 event wins over clear", d, 32'h1);
    wr(CTRL, 0); wr(STAT, 32'h1); rd(STAT, d); check("R8 clear after stop", d, 0);
  endtask

  initial begin
    #1;
    check("R1 irq during reset", {31'b0, irq}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_up_match();
    t_down_wrap();
    t_up_wrap_gated();
    t_ext_tick();
    t_disabled();
    t_write_wins();
    t_set_beats_clear();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule